// File: doc/BRIEF.md
# Sticky Any-Edge Delta Status Registers

This block keeps a bank of latched change flags for the alarm and status lines of a two-stage multiplexer. It covers three groups of seven second-stage tributary lines: loopback detected, reserved bit received, and demultiplexer clock lost. It also covers twenty-eight first-stage tributary clock-lost lines. Each flag is set when its line changes level, whether the line rises or falls. The flag then stays set until software clears it. A flag is never set again by a line that stays at one level.

Software reaches the flags through a simple 16-bit register port with an address, a read strobe and a write strobe. A single mode input selects how flags are cleared. In clear-on-read mode, reading a register returns its flags and clears them. In clear-on-write mode, software clears a flag by writing a one to its bit position. The status lines are sampled on the register clock, and each sample is compared with the sample from the previous cycle.

Top module: `delta_status_bank`

## Requirements
- R1: A change of a status line from 0 to 1 sets its flag. The flag is visible in the next read after the clock edge that samples the new level.
- R2: A change of a status line from 1 to 0 also sets its flag.
- R3: A flag that has been cleared stays 0 while its line holds a steady level, for any number of cycles.
- R4: Reset clears every flag and rd_data. The level a line has during reset does not set a flag once reset is released.
- R5: Address 0 holds the loopback flags, address 1 the reserved-bit flags and address 2 the demux clock-lost flags. In each, line i appears in bit i for bits 6:0, and bits 15:7 read 0.
- R6: The 28 first-stage flags appear in bits 7:0 in ascending order. Address 3 holds lines 0–7, address 4 lines 8–15 and address 5 lines 16–23. Address 6 holds lines 24–27 in bits 3:0. Every other bit reads 0, and address 7 reads 0x0000.
- R7: With cor_mode=1, a read returns the flag values held before the read. It clears only the flags of the addressed register.
- R8: With cor_mode=1, writes change no flag.
- R9: With cor_mode=0, a write clears each flag whose wr_data bit is 1 and leaves flags whose bit is 0 unchanged.
- R10: With cor_mode=0, reads clear no flag.
- R11: If a line changes in the same cycle in which its flag is cleared, the flag ends up set.
- R12: rd_data is registered. It updates on the clock edge that samples rd_en=1 and holds its value while rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cor_mode | input | 1 | 1 selects clear-on-read, 0 selects clear-on-write |
| lb_det_i | input | 7 | Second-stage loopback-detected lines |
| rsv_rcv_i | input | 7 | Second-stage reserved-bit-received lines |
| dmx_loc_i | input | 7 | Second-stage demux clock-lost lines |
| t1_loc_i | input | 28 | First-stage tributary clock-lost lines |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; ones mark flags to clear |
| rd_data | output | 16 | Registered read data |

## Verification
The bench holds several lines high through reset. A design that primed its history with zeros would report false changes on those lines. It drives rises and falls separately and then holds lines steady after a clear. This exposes a rising-only detector, and also a level-sensitive one that keeps setting the flag while the line stays high. It sets single bits at the edges of each register slice, such as lines 15, 16 and 27, and it reads the unused address. A wrong bit offset or non-zero reserved bits would show up there. It drives a line change in the same cycle as a write-one clear, where a design that gave the clear priority would drop the event. In both modes it tests reads and writes against each other. This catches a clear-on-read that wipes the wrong register or returns the cleared value, and writes or reads that act in the wrong mode.

// File: rtl/delta_pkg.sv
package delta_pkg;

  // Number of second-stage status groups, each mapped to one register
  localparam int N_GROUPS = 3;

  // Lowest flat flag index shown by register idx
  function automatic int reg_lo(input int idx, input int grp_w, input int slice);
    if (idx < N_GROUPS) return idx * grp_w;
    return N_GROUPS * grp_w + (idx - N_GROUPS) * slice;
  endfunction

  // Number of flags shown by register idx
  function automatic int reg_len(input int idx, input int grp_w, input int slice,
                                 input int t1_w);
    int rem;
    if (idx < N_GROUPS) return grp_w;
    rem = t1_w - (idx - N_GROUPS) * slice;
    return (rem < slice) ? rem : slice;
  endfunction

  // Total register count for a configuration
  function automatic int reg_count(input int slice, input int t1_w);
    return N_GROUPS + (t1_w + slice - 1) / slice;
  endfunction

endpackage

// File: rtl/delta_edge_latch.sv
module delta_edge_latch #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] delta_o
);

  logic [W-1:0] prev;
  logic         primed;
  logic [W-1:0] chg;

  // A change counts only once the history holds a real sample
  assign chg = primed ? (stat_i ^ prev) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      primed  <= 1'b0;
      delta_o <= '0;
    end else begin
      prev    <= stat_i;
      primed  <= 1'b1;
      // A new event wins over a clear in the same cycle
      delta_o <= (delta_o & ~clr_i) | chg;
    end
  end

  // R1 R2 R11: any sampled change leaves its flag set
  p_change_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (primed && (stat_i != prev)) |=>
      ((delta_o & $past(stat_i ^ prev)) == $past(stat_i ^ prev)));

  // R3: a flag only rises when its line changed
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    (delta_o & ~$past(delta_o) & ~$past(stat_i ^ prev)) == '0);

  // R9: a clear with no concurrent change leaves the flag at 0
  p_clear_takes_r9: assert property (@(posedge clk) disable iff (rst)
    (primed && ((clr_i & ~(stat_i ^ prev)) != '0)) |=>
      ((delta_o & $past(clr_i & ~(stat_i ^ prev))) == '0));

endmodule

// File: rtl/delta_reg_port.sv
module delta_reg_port
  import delta_pkg::*;
#(
  parameter int DW     = 16,
  parameter int G2_W   = 7,
  parameter int T1_W   = 28,
  parameter int SLICE  = 8,
  parameter int NFLAG  = 49,
  parameter int NREG   = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cor_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [NFLAG-1:0]  flags_i,
  output logic [NFLAG-1:0]  clr_o,
  output logic [DW-1:0]     rd_data
);

  logic [DW-1:0] reg_view [NREG];
  logic [NREG-1:0] hit;
  logic [DW-1:0] rd_mux;
  logic          rd_clr;
  logic          wr_clr;

  assign rd_clr = cor_mode & rd_en;
  assign wr_clr = ~cor_mode & wr_en;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int LO  = reg_lo(r, G2_W, SLICE);
    localparam int LEN = reg_len(r, G2_W, SLICE, T1_W);
    assign hit[r] = (addr == ADDR_W'(r));
    for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b < LEN) begin : g_live
        assign reg_view[r][b] = flags_i[LO+b];
        assign clr_o[LO+b]    = hit[r] & (rd_clr | (wr_clr & wr_data[b]));
      end else begin : g_rsvd
        assign reg_view[r][b] = 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit[r]) rd_mux = reg_view[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
    end
  end

  // R12: read data holds between reads
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R5: group registers never show reserved bits
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr < ADDR_W'(N_GROUPS))) |=> (rd_data[DW-1:G2_W] == '0));

endmodule

// File: rtl/delta_status_bank.sv
module delta_status_bank
  import delta_pkg::*;
#(
  parameter int DW    = 16,
  parameter int G2_W  = 7,
  parameter int T1_W  = 28,
  parameter int SLICE = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cor_mode,
  input  logic [G2_W-1:0]                      lb_det_i,
  input  logic [G2_W-1:0]                      rsv_rcv_i,
  input  logic [G2_W-1:0]                      dmx_loc_i,
  input  logic [T1_W-1:0]                      t1_loc_i,
  input  logic [$clog2(reg_count(8, 28))-1:0]  addr,
  input  logic                                 rd_en,
  input  logic                                 wr_en,
  input  logic [DW-1:0]                        wr_data,
  output logic [DW-1:0]                        rd_data
);

  localparam int NFLAG  = N_GROUPS * G2_W + T1_W;
  localparam int NREG   = reg_count(SLICE, T1_W);
  localparam int ADDR_W = $clog2(reg_count(8, 28));

  logic [NFLAG-1:0] stat_flat;
  logic [NFLAG-1:0] clr_flat;
  logic [NFLAG-1:0] delta_flat;

  assign stat_flat = {t1_loc_i, dmx_loc_i, rsv_rcv_i, lb_det_i};

  delta_edge_latch #(.W(NFLAG)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .stat_i  (stat_flat),
    .clr_i   (clr_flat),
    .delta_o (delta_flat)
  );

  delta_reg_port #(
    .DW     (DW),
    .G2_W   (G2_W),
    .T1_W   (T1_W),
    .SLICE  (SLICE),
    .NFLAG  (NFLAG),
    .NREG   (NREG),
    .ADDR_W (ADDR_W)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .cor_mode (cor_mode),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flags_i  (delta_flat),
    .clr_o    (clr_flat),
    .rd_data  (rd_data)
  );

  // R8 R10: in each mode the other strobe clears nothing
  p_wrong_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    ((cor_mode && !rd_en) || (!cor_mode && !wr_en)) |-> (clr_flat == '0));

endmodule

// File: tb/sim_delta_status_bank.sv
module sim_delta_status_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cor_mode = 1'b0;
  logic [6:0]  lb = '0, rsv = '0, dmx = '0;
  logic [27:0] loc = '0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  delta_status_bank u0 (
    .clk(clk), .rst(rst), .cor_mode(cor_mode),
    .lb_det_i(lb), .rsv_rcv_i(rsv), .dmx_loc_i(dmx), .t1_loc_i(loc),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int a = 0; a < 7; a++) wr(3'(a), 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    lb = 7'h55; loc = 28'h0F0_F0F0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 rd_data in reset", rd_data, 16'h0000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    cor_mode = 1'b0;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R4 no flag from reset level", v, 16'h0000);
    end
  endtask

  task automatic t_edges();
    logic [15:0] v;
    @(negedge clk); lb = 7'h57; settle();
    rd(3'd0, v); chk("R1 rise sets", v, 16'h0002);
    wr(3'd0, 16'h0002);
    rd(3'd0, v); chk("R9 clear after rise", v, 16'h0000);
    @(negedge clk); lb = 7'h56; settle();
    rd(3'd0, v); chk("R2 fall sets", v, 16'h0001);
    wr(3'd0, 16'h0001);
    repeat (6) @(negedge clk);
    rd(3'd0, v); chk("R3 steady stays clear", v, 16'h0000);
  endtask

  task automatic t_map();
    logic [15:0] v;
    @(negedge clk);
    rsv[6] = ~rsv[6]; dmx[0] = ~dmx[0];
    loc[0] = ~loc[0]; loc[15] = ~loc[15]; loc[16] = ~loc[16]; loc[27] = ~loc[27];
    settle();
    rd(3'd1, v); chk("R5 reserved-bit group map", v, 16'h0040);
    rd(3'd2, v); chk("R5 demux group map", v, 16'h0001);
    rd(3'd3, v); chk("R6 lines 0-7", v, 16'h0001);
    rd(3'd4, v); chk("R6 lines 8-15", v, 16'h0080);
    rd(3'd5, v); chk("R6 lines 16-23", v, 16'h0001);
    rd(3'd6, v); chk("R6 lines 24-27", v, 16'h0008);
    clear_all();
    @(negedge clk);
    lb = ~lb; rsv = ~rsv; dmx = ~dmx; loc = ~loc;
    settle();
    rd(3'd0, v); chk("R5 all loopback bits", v, 16'h007F);
    rd(3'd1, v); chk("R5 all reserved-bit bits", v, 16'h007F);
    rd(3'd2, v); chk("R5 all demux bits", v, 16'h007F);
    rd(3'd3, v); chk("R6 full slice 0", v, 16'h00FF);
    rd(3'd4, v); chk("R6 full slice 1", v, 16'h00FF);
    rd(3'd5, v); chk("R6 full slice 2", v, 16'h00FF);
    rd(3'd6, v); chk("R6 top slice", v, 16'h000F);
    rd(3'd7, v); chk("R6 unused address", v, 16'h0000);
    clear_all();
  endtask

  task automatic t_cow();
    logic [15:0] v;
    @(negedge clk); dmx = ~dmx; settle();
    wr(3'd2, 16'h0005);
    rd(3'd2, v); chk("R9 partial write-one clear", v, 16'h007A);
    rd(3'd2, v); chk("R10 read keeps flags", v, 16'h007A);
    @(negedge clk); lb[4] = ~lb[4];
    repeat (3) @(negedge clk);
    chk("R12 rd_data holds", rd_data, 16'h007A);
    rd(3'd0, v); chk("R12 next read updates", v, 16'h0010);
    clear_all();
  endtask

  task automatic t_collision();
    logic [15:0] v;
    @(negedge clk); lb[2] = ~lb[2]; settle();
    @(negedge clk);
    addr = 3'd0; wr_en = 1'b1; wr_data = 16'h0004; lb[2] = ~lb[2];
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(3'd0, v); chk("R11 event beats clear", v, 16'h0004);
    clear_all();
  endtask

  task automatic t_cor();
    logic [15:0] v;
    cor_mode = 1'b1;
    @(negedge clk); lb[3:0] = ~lb[3:0]; rsv[0] = ~rsv[0]; settle();
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R8/R7 write ignored, pre-clear value", v, 16'h000F);
    rd(3'd0, v); chk("R7 read cleared", v, 16'h0000);
    rd(3'd1, v); chk("R7 other register kept", v, 16'h0001);
    rd(3'd1, v); chk("R7 second register cleared", v, 16'h0000);
    cor_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_edges();
    t_map();
    t_cow();
    t_collision();
    t_cor();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule